// File: doc/BRIEF.md
# Port-mapped I/O write decoder

This block is the peripheral-side glue on a small microcontroller's port bus. The processor presents an 8-bit port id and 8-bit output data, and raises one of three strobes. A normal write strobe captures the data into one of eight output registers, decoded from the full 8-bit id. A constant-write strobe captures the data into a separate group of sixteen registers, decoded from the low four id bits only.

On the input side, a registered multiplexer turns the port id into the input data returned to the processor. Peripherals that clear status on a read get a one-cycle acknowledge pulse on the lane of the port that was read. A sleep input freezes the block while the processor is asleep. Strobes have no effect during sleep and every register holds its value.

Top module: `port_io_decoder`

## Requirements
- R1: While rst_ni is low, all output registers, all constant registers, in_data_o and rd_ack_o are zero.
- R2: When wr_stb_i is high and sleep_i is low, with port_id_i equal to k for k in 0..7, output register k (bits k*8+7..k*8 of out_regs_o) takes out_data_i at that clock edge. The other output registers are unchanged.
- R3: When wr_const_stb_i is high and sleep_i is low, constant register port_id_i[3:0] (bits j*8+7..j*8 of const_regs_o) takes out_data_i at that edge. Bits 7..4 of the id have no effect on which register is chosen.
- R4: Each clock edge with sleep_i low loads in_data_o with input port port_id_i (bits k*8+7..k*8 of in_ports_i) when the id is 0..7. For ids 8..255 it loads 00.
- R5: When rd_stb_i is high and sleep_i is low with id k in 0..7, rd_ack_o is exactly bit k set in the following cycle. In all other cycles it is 0. At most one bit is ever set.
- R6: While sleep_i is high, no write strobe changes any register and in_data_o holds its value. rd_ack_o is 0 in the following cycle.
- R7: A normal write and a constant write in the same cycle both take effect.
- R8: A normal write to an id of 8 or more changes neither the output registers nor the constant registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Processor sleep: freezes the block |
| port_id_i | input | 8 | Port address from the processor |
| out_data_i | input | 8 | Write data from the processor |
| wr_stb_i | input | 1 | Normal write strobe |
| wr_const_stb_i | input | 1 | Constant write strobe (low id nibble decode) |
| rd_stb_i | input | 1 | Read strobe |
| in_ports_i | input | 64 | Eight 8-bit input ports, port k at bits k*8+7..k*8 |
| out_regs_o | output | 64 | Eight output registers, port k at bits k*8+7..k*8 |
| const_regs_o | output | 128 | Sixteen constant registers, index j at bits j*8+7..j*8 |
| in_data_o | output | 8 | Registered input data returned to the processor |
| rd_ack_o | output | 8 | One-cycle read acknowledge per input port |

## Verification
The bench targets constant writes whose upper id bits are set. A decoder that used all eight bits for these writes would drop them or send them to the wrong register. It also sends normal writes to ids above 7, which a decoder that truncated the id would alias onto registers 0..7. Both strobes are raised in the same cycle, which catches a design that lets one path block the other. Strobes are also raised during sleep, where any write leak, acknowledge pulse or change of in_data_o would show up. Every clock, a behavioural model is compared against all outputs under random traffic.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
  localparam int DATA_W   = 8;
  localparam int ID_W     = 8;
  localparam int K_ID_W   = 4;
  localparam int N_K_REGS = 1 << K_ID_W;
endpackage

// File: rtl/io_reg_bank.sv
module io_reg_bank #(
  parameter int DW    = 8,
  parameter int N_REG = 8,
  parameter int SEL_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [DW-1:0]       data_i,
  output logic [N_REG*DW-1:0] regs_o
);
  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    logic          hit;
    logic [DW-1:0] q;
    assign hit = we_i && (sel_i == SEL_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (hit) q <= data_i;
    end
    assign regs_o[i*DW +: DW] = q;

    AST_WR_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && sel_i == SEL_W'(i)) |=> regs_o[i*DW +: DW] == $past(data_i)); // R2
    AST_NO_STRAY_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && sel_i == SEL_W'(i)) |=> $stable(regs_o[i*DW +: DW])); // R8
  end
endmodule

// File: rtl/io_in_sel.sv
module io_in_sel #(
  parameter int DW    = 8,
  parameter int N_IN  = 8,
  parameter int SEL_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hold_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               rd_stb_i,
  input  logic [N_IN*DW-1:0] in_ports_i,
  output logic [DW-1:0]      in_data_o,
  output logic [N_IN-1:0]    rd_ack_o
);
  logic [DW-1:0]   mux_d;
  logic [N_IN-1:0] dec;

  for (genvar i = 0; i < N_IN; i++) begin : g_dec
    assign dec[i] = (sel_i == SEL_W'(i));
  end

  // one-hot dec, unmapped ids leave mux_d at zero
  always_comb begin
    mux_d = '0;
    for (int i = 0; i < N_IN; i++)
      if (dec[i]) mux_d = in_ports_i[i*DW +: DW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_data_o <= '0;
      rd_ack_o  <= '0;
    end else if (hold_i) begin
      rd_ack_o  <= '0;
    end else begin
      in_data_o <= mux_d;
      rd_ack_o  <= rd_stb_i ? dec : '0;
    end
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_ack_o)); // R5
  AST_ACK_NEEDS_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_stb_i && !hold_i) |=> rd_ack_o == '0); // R5
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && int'(sel_i) >= N_IN) |=> in_data_o == '0); // R4
  AST_HOLD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(in_data_o)); // R6
endmodule

// File: rtl/port_io_decoder.sv
module port_io_decoder
  import io_dec_pkg::*;
#(
  parameter int N_OUT = 8,
  parameter int N_IN  = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sleep_i,
  input  logic [ID_W-1:0]            port_id_i,
  input  logic [DATA_W-1:0]          out_data_i,
  input  logic                       wr_stb_i,
  input  logic                       wr_const_stb_i,
  input  logic                       rd_stb_i,
  input  logic [N_IN*DATA_W-1:0]     in_ports_i,
  output logic [N_OUT*DATA_W-1:0]    out_regs_o,
  output logic [N_K_REGS*DATA_W-1:0] const_regs_o,
  output logic [DATA_W-1:0]          in_data_o,
  output logic [N_IN-1:0]            rd_ack_o
);
  logic wr_en, k_en;
  assign wr_en = wr_stb_i && !sleep_i;
  assign k_en  = wr_const_stb_i && !sleep_i;

  io_reg_bank #(.DW(DATA_W), .N_REG(N_OUT), .SEL_W(ID_W)) i_out_bank (
    .clk_i, .rst_ni, .we_i(wr_en), .sel_i(port_id_i),
    .data_i(out_data_i), .regs_o(out_regs_o));

  io_reg_bank #(.DW(DATA_W), .N_REG(N_K_REGS), .SEL_W(K_ID_W)) i_const_bank (
    .clk_i, .rst_ni, .we_i(k_en), .sel_i(port_id_i[K_ID_W-1:0]),
    .data_i(out_data_i), .regs_o(const_regs_o));

  io_in_sel #(.DW(DATA_W), .N_IN(N_IN), .SEL_W(ID_W)) i_in_sel (
    .clk_i, .rst_ni, .hold_i(sleep_i), .sel_i(port_id_i),
    .rd_stb_i, .in_ports_i, .in_data_o, .rd_ack_o);

  AST_SLEEP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> $stable(out_regs_o) && $stable(const_regs_o) && rd_ack_o == '0); // R6
  AST_CONST_NIBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k_en |=> const_regs_o[$past(port_id_i[K_ID_W-1:0])*DATA_W +: DATA_W] == $past(out_data_i)); // R3
  AST_DUAL_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && k_en && int'(port_id_i) < N_OUT) |=>
      out_regs_o[$past(port_id_i[2:0])*DATA_W +: DATA_W] == $past(out_data_i)); // R7
endmodule

// File: tb/test_port_io_decoder.sv
`timescale 1ns/1ps
module test_port_io_decoder;
  logic         clk = 0, rst_n = 0, sleep = 0;
  logic [7:0]   id = 0, dout = 0;
  logic         wr = 0, kwr = 0, rd = 0;
  logic [63:0]  in_ports = 0;
  logic [63:0]  out_regs;
  logic [127:0] const_regs;
  logic [7:0]   in_data, rd_ack;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  port_io_decoder i_port_io_decoder (
    .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep), .port_id_i(id), .out_data_i(dout),
    .wr_stb_i(wr), .wr_const_stb_i(kwr), .rd_stb_i(rd), .in_ports_i(in_ports),
    .out_regs_o(out_regs), .const_regs_o(const_regs), .in_data_o(in_data), .rd_ack_o(rd_ack));

  // behavioural reference model
  byte unsigned m_out[8], m_k[16], m_in, m_ack;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_out[i]) m_out[i] = 0;
      foreach (m_k[i]) m_k[i] = 0;
      m_in = 0; m_ack = 0;
    end else if (sleep) begin
      m_ack = 0;
    end else begin
      if (wr && id < 8) m_out[id] = dout;
      if (kwr) m_k[id % 16] = dout;
      m_in  = (id < 8) ? in_ports[id*8 +: 8] : 8'h00;
      m_ack = (rd && id < 8) ? byte'(1 << id) : 8'h00;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    for (int i = 0; i < 8; i++)  chk("R2 model out", out_regs[i*8 +: 8], m_out[i]);
    for (int i = 0; i < 16; i++) chk("R3 model const", const_regs[i*8 +: 8], m_k[i]);
    chk("R4 model in_data", in_data, m_in);
    chk("R5 model rd_ack", rd_ack, m_ack);
  end

  task automatic tick(); @(posedge clk); #5; endtask
  task automatic idle(); wr = 0; kwr = 0; rd = 0; endtask

  task automatic finish_up();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20ns * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 8; i++) in_ports[i*8 +: 8] = 8'hA0 + 8'(i);
    #35;
    // r1_ reset state
    for (int i = 0; i < 8; i++)  chk("R1 out reset", out_regs[i*8 +: 8], 8'h00);
    for (int i = 0; i < 16; i++) chk("R1 const reset", const_regs[i*8 +: 8], 8'h00);
    chk("R1 in_data reset", in_data, 8'h00);
    chk("R1 ack reset", rd_ack, 8'h00);
    @(posedge clk); #5; rst_n = 1;

    // R2 normal writes
    for (int i = 0; i < 8; i++) begin
      id = 8'(i); dout = 8'h10 + 8'(i); wr = 1; tick();
    end
    idle();
    for (int i = 0; i < 8; i++) chk("R2 write", out_regs[i*8 +: 8], 8'h10 + 8'(i));

    // R8 unmapped normal write
    id = 8'h83; dout = 8'hEE; wr = 1; tick(); idle();
    chk("R8 unmapped out3", out_regs[3*8 +: 8], 8'h13);
    chk("R8 unmapped const3", const_regs[3*8 +: 8], 8'h00);

    // R3 constant write, upper id bits ignored
    id = 8'hF5; dout = 8'h77; kwr = 1; tick(); idle();
    chk("R3 const nibble", const_regs[5*8 +: 8], 8'h77);
    chk("R3 out untouched", out_regs[5*8 +: 8], 8'h15);

    // R7 both strobes together
    id = 8'h02; dout = 8'h99; wr = 1; kwr = 1; tick(); idle();
    chk("R7 dual out", out_regs[2*8 +: 8], 8'h99);
    chk("R7 dual const", const_regs[2*8 +: 8], 8'h99);

    // R4 input mux
    id = 8'h04; tick();
    chk("R4 in port4", in_data, 8'hA4);
    id = 8'h40; tick();
    chk("R4 unmapped zero", in_data, 8'h00);

    // R5 read acknowledge
    id = 8'h06; rd = 1; tick(); rd = 0;
    chk("R5 ack pulse", rd_ack, 8'h40);
    tick();
    chk("R5 ack clears", rd_ack, 8'h00);
    id = 8'h09; rd = 1; tick(); rd = 0;
    chk("R5 ack unmapped", rd_ack, 8'h00);

    // R6 sleep freezes
    id = 8'h01; tick();
    sleep = 1; id = 8'h03; dout = 8'h55; wr = 1; kwr = 1; rd = 1; tick();
    chk("R6 sleep out", out_regs[3*8 +: 8], 8'h13);
    chk("R6 sleep const", const_regs[3*8 +: 8], 8'h00);
    chk("R6 sleep in_data", in_data, 8'hA1);
    chk("R6 sleep ack", rd_ack, 8'h00);
    idle(); sleep = 0; tick();
    chk("R6 wake in_data", in_data, 8'hA3);

    // random traffic
    for (int n = 0; n < 400; n++) begin
      id = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 9));
      dout = 8'($urandom);
      wr = 1'($urandom); kwr = 1'($urandom); rd = 1'($urandom);
      sleep = ($urandom_range(0, 7) == 0);
      if (n % 50 == 0) in_ports = {$urandom, $urandom};
      tick();
    end
    idle(); sleep = 0; tick();
    finish_up();
  end
endmodule